// File: doc/BRIEF.md
# TDM Quadrant Bit Substitution Unit

This block sits on one serial time-division-multiplexed input stream on its way into a switch fabric. It receives one data bit per clock, and a frame pulse marks the first bit of each frame. The stream rate can be 2.048, 4.096, 8.192 or 16.384 Mbps. That rate fixes the number of 8-bit channels in a frame: 32, 64, 128 or 256. The block counts bit and channel positions inside the frame and divides the channels into four equal quarters.

Each quarter has its own 3-bit code in a control register. A code either leaves the channels of that quarter untouched, or forces the most or least significant bit of every channel in that quarter to a fixed level. The output is the input delayed by one clock, with the substitution applied. Until the first frame pulse after reset, the position is unknown, so data passes through unchanged.

A two-state sequencer tracks alignment. **HUNT** is entered at reset and passes every bit through. The transition **HUNT→LOCK** is taken on the first frame pulse. **LOCK** keeps the counters running and is left only by reset. The counters wrap at the frame length even when no frame pulse arrives, and any frame pulse in LOCK restarts them at position zero.

Top module: `tdm_quad_subst`

## Requirements
- R1: After reset the control readback is 0x0000, `ser_out` is 0 and the sequencer is in HUNT.
- R2: When the active code of a channel has bit 2 clear (codes 000 to 011), every bit of that channel appears on `ser_out` unchanged one clock after it is sampled on `ser_in`.
- R3: The bit sampled while `frame_pulse` is high is bit 0 (the MSB) of channel 0. Bits follow MSB first, so bit 7 of each channel is its LSB.
- R4: `rate_sel` = 0, 1, 2, 3 selects 32, 64, 128, 256 channels per frame. Without a frame pulse, the position wraps from the last bit of the last channel to bit 0 of channel 0.
- R5: The quarter of a channel is its index divided by one quarter of the frame length. For example, quarter 2 spans channels 16–23, 32–47, 64–95 and 128–191 for `rate_sel` 0 to 3.
- R6: Code 100 forces bit 7 (LSB) of each channel in the quarter to 0. Code 101 forces it to 1. The other bits pass unchanged.
- R7: Code 110 forces bit 0 (MSB) of each channel in the quarter to 0. Code 111 forces it to 1. The other bits pass unchanged.
- R8: A write with `wr_en` high loads `wr_data`. Quarter 0 takes bits 2:0, quarter 1 bits 5:3, quarter 2 bits 8:6 and quarter 3 bits 11:9. Bits 15:12 are dropped and read as 0 on `ctrl_rd`, which shows the register from the clock after the write.
- R9: A channel uses the code its quarter holds in the cycle of its bit 0, for all eight bits. A write later in that channel first affects the next channel.
- R10: In HUNT (no frame pulse since reset), every bit passes unchanged whatever the register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 2 | Stream rate: 0=2.048, 1=4.096, 2=8.192, 3=16.384 Mbps |
| frame_pulse | input | 1 | High during the first bit of a frame |
| ser_in | input | 1 | Serial data in |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 16 | Control register write value |
| ser_out | output | 1 | Serial data out, one clock behind `ser_in` |
| ctrl_rd | output | 16 | Control register readback |

## Verification
Every output bit is due exactly one clock after its input bit is sampled. The behavioural model in the bench produces its expected bit at the same rising edge as the design, and the two are compared at the next falling edge. A register write is visible on `ctrl_rd` at the falling edge that follows the write edge, and is checked there. Its effect on data is expected from the next channel boundary, so the model latches a code only on bit 0 of a channel, just as R9 requires.

// File: rtl/tdm_qs_pkg.sv
package tdm_qs_pkg;
    localparam int BITS_PER_CH = 8;
    localparam int BIT_W       = $clog2(BITS_PER_CH);
    localparam int CH_W        = 8;
    localparam int FIELD_W     = 3;
    localparam int NQUAD       = 4;
    localparam int USED_W      = NQUAD * FIELD_W;
    localparam int CTRL_W      = 16;

    typedef enum logic [1:0] {
        RATE_2M  = 2'd0,
        RATE_4M  = 2'd1,
        RATE_8M  = 2'd2,
        RATE_16M = 2'd3
    } rate_e;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } sync_e;

    typedef logic [FIELD_W-1:0] code_t;
endpackage

// File: rtl/tdm_qs_ctrl_reg.sv
module tdm_qs_ctrl_reg
    import tdm_qs_pkg::*;
#(
    parameter int P_CTRL_W = CTRL_W,
    parameter int P_USED_W = USED_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [P_CTRL_W-1:0] wr_data,
    output logic [P_USED_W-1:0] fields,
    output logic [P_CTRL_W-1:0] ctrl_rd
);
    localparam int PAD_W = P_CTRL_W - P_USED_W;

    logic [P_USED_W-1:0] reg_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_q <= '0;
        else if (wr_en)
            reg_q <= wr_data[P_USED_W-1:0];
    end

    assign fields  = reg_q;
    assign ctrl_rd = {{PAD_W{1'b0}}, reg_q};
endmodule

// File: rtl/tdm_qs_timing.sv
module tdm_qs_timing
    import tdm_qs_pkg::*;
#(
    parameter int P_CH_W  = CH_W,
    parameter int P_BIT_W = BIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rate_e             rate,
    input  logic              fp,
    output logic              in_frame,
    output logic [P_BIT_W-1:0] bit_pos,
    output logic [P_CH_W-1:0]  ch_pos,
    output logic [1:0]        quad
);
    localparam logic [P_BIT_W-1:0] LAST_BIT = P_BIT_W'(BITS_PER_CH - 1);
    localparam int SH_BASE = P_CH_W - 5;

    sync_e             state, state_nxt;
    logic [P_BIT_W-1:0] bit_q;
    logic [P_CH_W-1:0]  ch_q;
    logic [P_CH_W-1:0]  ch_mask;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_HUNT;
        else
            state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HUNT: if (fp) state_nxt = ST_LOCK;
            ST_LOCK: state_nxt = ST_LOCK;
        endcase
    end

    always_comb begin
        in_frame = fp || (state == ST_LOCK);
        bit_pos  = fp ? '0 : bit_q;
        ch_pos   = fp ? '0 : ch_q;
        ch_mask  = {P_CH_W{1'b1}} >> (3 - int'(rate));
        quad     = 2'(ch_pos >> (SH_BASE + int'(rate)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= '0;
            ch_q  <= '0;
        end else if (in_frame) begin
            bit_q <= bit_pos + 1'b1;
            if (bit_pos == LAST_BIT)
                ch_q <= (ch_pos + 1'b1) & ch_mask;
            else
                ch_q <= ch_pos;
        end
    end
endmodule

// File: rtl/tdm_qs_subst.sv
module tdm_qs_subst
    import tdm_qs_pkg::*;
#(
    parameter int P_BIT_W  = BIT_W,
    parameter int P_USED_W = USED_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                din,
    input  logic                in_frame,
    input  logic [P_BIT_W-1:0]  bit_pos,
    input  logic [1:0]          quad,
    input  logic [P_USED_W-1:0] fields,
    output code_t               act_code,
    output logic                dout
);
    localparam logic [P_BIT_W-1:0] LSB_POS = P_BIT_W'(BITS_PER_CH - 1);

    code_t code_q;
    code_t field_sel;
    logic  forced;
    logic  nxt_bit;

    always_comb begin
        field_sel = fields[int'(quad)*FIELD_W +: FIELD_W];
        if (!in_frame)
            act_code = '0;
        else if (bit_pos == '0)
            act_code = field_sel;
        else
            act_code = code_q;
        forced  = act_code[2] && (act_code[1] ? (bit_pos == '0) : (bit_pos == LSB_POS));
        nxt_bit = forced ? act_code[0] : din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            dout   <= 1'b0;
        end else begin
            code_q <= act_code;
            dout   <= nxt_bit;
        end
    end
endmodule

// File: rtl/tdm_quad_subst.sv
module tdm_quad_subst
    import tdm_qs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  rate_sel,
    input  logic        frame_pulse,
    input  logic        ser_in,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic        ser_out,
    output logic [15:0] ctrl_rd
);
    logic [USED_W-1:0] fields;
    logic              in_frame;
    logic [BIT_W-1:0]  bit_pos;
    logic [CH_W-1:0]   ch_pos;
    logic [1:0]        quad;
    code_t             act_code;

    tdm_qs_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .fields  (fields),
        .ctrl_rd (ctrl_rd)
    );

    tdm_qs_timing u_tim (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate     (rate_e'(rate_sel)),
        .fp       (frame_pulse),
        .in_frame (in_frame),
        .bit_pos  (bit_pos),
        .ch_pos   (ch_pos),
        .quad     (quad)
    );

    tdm_qs_subst u_sub (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (ser_in),
        .in_frame (in_frame),
        .bit_pos  (bit_pos),
        .quad     (quad),
        .fields   (fields),
        .act_code (act_code),
        .dout     (ser_out)
    );
endmodule

// File: rtl/tdm_qs_checker.sv
module tdm_qs_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  rate_sel,
    input logic        frame_pulse,
    input logic        ser_in,
    input logic        ser_out,
    input logic [15:0] ctrl_rd,
    input logic        in_frame,
    input logic [2:0]  bit_pos,
    input logic [7:0]  ch_pos,
    input logic [2:0]  act_code
);
    logic armed;

    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd[15:12] == 4'h0);

    a_r3_pulse_restart: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(frame_pulse) && !frame_pulse |-> (bit_pos == 3'd1) && (ch_pos == 8'd0));

    a_r4_channel_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ch_pos) < (32 << rate_sel));

    a_r9_code_held: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(in_frame) && in_frame && (bit_pos != 3'd0) |-> act_code == $past(act_code));

    a_r2_pass_code: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(act_code[2] == 1'b0) |-> ser_out == $past(ser_in));

    a_r10_hunt_pass: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(!in_frame) |-> ser_out == $past(ser_in));

    a_r6_lsb_zero: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(act_code == 3'b100 && bit_pos == 3'd7) |-> ser_out == 1'b0);

    a_r7_msb_one: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(act_code == 3'b111 && bit_pos == 3'd0) |-> ser_out == 1'b1);
endmodule

bind tdm_quad_subst tdm_qs_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rate_sel    (rate_sel),
    .frame_pulse (frame_pulse),
    .ser_in      (ser_in),
    .ser_out     (ser_out),
    .ctrl_rd     (ctrl_rd),
    .in_frame    (in_frame),
    .bit_pos     (bit_pos),
    .ch_pos      (ch_pos),
    .act_code    (act_code)
);

// File: tb/tb_tdm_quad_subst.sv
module tb_tdm_quad_subst;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  rate_sel = 2'd0;
    logic        frame_pulse = 1'b0;
    logic        ser_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic        ser_out;
    logic [15:0] ctrl_rd;

    int    n_checks = 0;
    int    n_fail = 0;
    string tag = "R1";
    bit    done = 1'b0;

    always #5 clk = ~clk;

    tdm_quad_subst dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rate_sel    (rate_sel),
        .frame_pulse (frame_pulse),
        .ser_in      (ser_in),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .ser_out     (ser_out),
        .ctrl_rd     (ctrl_rd)
    );

    // behavioural reference
    bit  m_lock;
    int  m_bit, m_ch, m_code, m_ctrl;
    bit  exp_out;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lock = 0; m_bit = 0; m_ch = 0; m_code = 0; m_ctrl = 0; exp_out = 0;
        end else begin
            int nch, q;
            nch = 32 << rate_sel;
            if (frame_pulse) begin
                m_lock = 1; m_bit = 0; m_ch = 0;
            end
            if (!m_lock) begin
                exp_out = ser_in;
            end else begin
                if (m_bit == 0) begin
                    q = m_ch / (nch / 4);
                    m_code = (m_ctrl >> (3 * q)) & 7;
                end
                exp_out = ser_in;
                if (m_code >= 4) begin
                    if ((m_code & 2) != 0) begin
                        if (m_bit == 0) exp_out = m_code[0];
                    end else begin
                        if (m_bit == 7) exp_out = m_code[0];
                    end
                end
                m_bit = m_bit + 1;
                if (m_bit == 8) begin
                    m_bit = 0;
                    m_ch = (m_ch + 1) % nch;
                end
            end
            if (wr_en) m_ctrl = wr_data & 16'h0FFF;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) check(tag, ser_out, exp_out);
    end

    // mode: 0 random, 1 all ones, 2 all zeros
    task automatic run_bits(input int n, input int mode, input bit with_fp,
                            input int wr_at, input logic [15:0] wr_val);
        for (int i = 0; i < n; i++) begin
            frame_pulse = with_fp && (i == 0);
            ser_in = (mode == 0) ? 1'($urandom) : (mode == 1);
            wr_en = (i == wr_at);
            wr_data = wr_val;
            @(negedge clk);
        end
        frame_pulse = 1'b0;
        wr_en = 1'b0;
    endtask

    task automatic write_reg(input logic [15:0] v, input string req);
        wr_en = 1'b1;
        wr_data = v;
        ser_in = 1'($urandom);
        @(negedge clk);
        wr_en = 1'b0;
        check(req, ctrl_rd, v & 16'h0FFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", ser_out, 0);
        check("R1", ctrl_rd, 0);

        // R8: field layout and reserved bits dropped
        write_reg(16'hFFFF, "R8");
        write_reg(16'hF000 | {4'h0, 3'd7, 3'd4, 3'd6, 3'd5}, "R8");

        // R10: no frame pulse yet, data passes despite nonzero register
        tag = "R10";
        run_bits(40, 0, 1'b0, -1, 16'h0);

        // R3 R4 R5 R6 R7 per rate, two frames with wrap and no second pulse
        for (int r = 0; r < 4; r++) begin
            int nb;
            rate_sel = 2'(r);
            nb = (32 << r) * 8;
            tag = "R3 R4 R5 R6 R7";
            run_bits(nb, 0, 1'b1, -1, 16'h0);
            tag = "R4 wrap";
            run_bits(nb, (r % 2) + 1, 1'b0, -1, 16'h0);
        end

        // R6 R7 with other polarity, fixed patterns
        rate_sel = 2'd1;
        write_reg({4'h0, 3'd6, 3'd5, 3'd4, 3'd7}, "R8");
        tag = "R6 R7";
        run_bits(512, 1, 1'b1, -1, 16'h0);
        run_bits(512, 2, 1'b1, -1, 16'h0);

        // R9: writes landing mid-channel
        tag = "R9";
        run_bits(300, 0, 1'b1, 101, {4'h0, 3'd5, 3'd5, 3'd5, 3'd5});
        run_bits(300, 2, 1'b0, 45, {4'h0, 3'd7, 3'd7, 3'd7, 3'd7});
        run_bits(300, 1, 1'b0, 203, {4'h0, 3'd4, 3'd6, 3'd4, 3'd6});

        // R2: codes with bit 2 clear pass data
        write_reg({4'h0, 3'd3, 3'd1, 3'd2, 3'd0}, "R8");
        tag = "R2";
        rate_sel = 2'd2;
        run_bits(1024, 0, 1'b1, -1, 16'h0);

        // R3: pulse restarts mid-frame
        tag = "R3";
        rate_sel = 2'd0;
        write_reg({4'h0, 3'd7, 3'd6, 3'd5, 3'd4}, "R8");
        run_bits(77, 0, 1'b1, -1, 16'h0);
        run_bits(256, 0, 1'b1, -1, 16'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule